// File: doc/BRIEF.md
# Serial Configuration Port with Soft-Reset Sequencing

This block is the configuration entry point of a frequency-synthesis subsystem. A host drives three wires: a serial clock, a serial data line and a latch strobe. While the latch strobe is low, the block collects a 24-bit word one bit at a time, most significant bit first. On the rising edge of the latch strobe, the last four bits collected select a register and the other twenty bits are written into it. All three wires are brought into the system clock domain through a short synchronizer before any edge is detected.

One register controls power. Setting its reset bit returns every register to its default and leaves every enable off. The block then holds in reset until a second power write clears that bit. Only a third power write turns enables on. A write to address 0 always emits a one-cycle calibration-start pulse, even when the value is unchanged. A chip-enable input gates the power enables without clearing any register, and it raises a flag when register 0 must be rewritten before relock. Every register is visible on a flat read-back bus.

Top module: `cfg_serial_port`

## Requirements
- R1: A bit on `ser_dat` is shifted in on each rising edge of `ser_clk` while `ser_le` is low, most significant bit first. Clock edges while `ser_le` is high shift nothing. Of the 24 bits held, bits [3:0] are the address and bits [23:4] are the payload.
- R2: On each rising edge of `ser_le`, the payload is written into the register at the held address when that address is accepted. Register a is read back on `reg_rd[a*20 +: 20]`.
- R3: Addresses 10, 11 and 13 are hidden registers. Each holds `{12'hC3A, a[3:0], 4'h0}` and is never changed by a serial write. Writes to 14 and 15 are dropped. Neither kind produces a write strobe.
- R4: Address 5 is the power register. Payload bit 19 is its reset bit and payload bits [7:0] are the eight enables. A power write with bit 19 set clears every user register (0–9 and 12) to zero, restores the hidden defaults and enters a held state.
- R5: In the held state, writes to any address other than 5 are ignored. A power write with bit 19 clear leaves the held state, but its payload is discarded and all enables stay 0.
- R6: Outside the held state, a power write with bit 19 clear stores the payload, and `pwr_en` equals its bits [7:0] while chip enable is high.
- R7: Every accepted write to address 0 produces exactly one `cal_start` pulse, one clock wide, even when the value is unchanged. No pulse occurs while held.
- R8: Every accepted write, including power writes in the held state, produces one one-cycle `wr_stb` pulse, with `wr_addr` giving the address.
- R9: While `chip_en` is low, `pwr_en` is 0 and all registers keep their contents. A falling `chip_en` sets `relock_req`. An accepted address-0 write while `chip_en` is high clears it.
- R10: An active-low `rst_n` asynchronously restores all defaults, leaves the held state and clears `relock_req` and the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; rising edge commits the word |
| chip_en | input | 1 | Chip enable; low gates all power enables |
| pwr_en | output | 8 | Gated power enables from the power register |
| cal_start | output | 1 | One-cycle calibration-start pulse |
| wr_stb | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | 4 | Address of the write flagged by `wr_stb` |
| relock_req | output | 1 | Register 0 must be rewritten before relock |
| reg_rd | output | 320 | Flat read-back of all sixteen 20-bit registers |

## Verification
The bench goes after the three-step power sequence, covering each of these errors:
- A design that applies the releasing write's payload would light enables one write too early.
- A design that accepts other writes while held would corrupt cleared registers.
- A design that fires calibration in the held state would also be caught.

It repeats an identical address-0 write, because a design that pulses only on a change would lose the second calibration. It toggles the serial clock with the strobe held high and then re-latches. A shifter that ignores the strobe level would commit a different word. It also writes hidden and unassigned addresses, where a loose decoder would overwrite defaults or strobe.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int unsigned WORD_W   = 24;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = WORD_W - ADDR_W;
    localparam int unsigned NREG     = 1 << ADDR_W;
    localparam int unsigned PWR_ADDR = 5;
    localparam int unsigned CAL_ADDR = 0;
    localparam int unsigned RST_BIT  = 19;
    localparam int unsigned NPWR     = 8;
    localparam int unsigned RD_W     = NREG * DATA_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    function automatic logic is_hidden(addr_t a);
        return (a == addr_t'(10)) || (a == addr_t'(11)) || (a == addr_t'(13));
    endfunction

    function automatic logic is_user(addr_t a);
        return (a <= addr_t'(9)) || (a == addr_t'(12));
    endfunction

    function automatic data_t reset_val(addr_t a);
        data_t v;
        v = '0;
        if (is_hidden(a)) v = {12'hC3A, a, 4'h0};
        return v;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              sle_s,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    typedef struct packed {
        logic              sclk;
        logic              le;
        logic [WORD_W-1:0] sr;
        logic              vld;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d      = shf_q;
        shf_d.sclk = sclk_s;
        shf_d.le   = sle_s;
        // latch strobe rising edge commits the held word
        shf_d.vld  = sle_s & ~shf_q.le;
        if (sclk_s && !shf_q.sclk && !sle_s) begin
            shf_d.sr = {shf_q.sr[WORD_W-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign word_o     = shf_q.sr;
    assign word_vld_o = shf_q.vld;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              ce_s,
    output logic [RD_W-1:0]   reg_rd,
    output logic [NPWR-1:0]   pwr_en,
    output logic              cal_start,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              relock_req
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        held;
        logic                        cal;
        logic                        stb;
        addr_t                       waddr;
        logic                        relock;
        logic                        ce;
    } rf_t;

    function automatic rf_t rf_init();
        rf_t r;
        r = '0;
        for (int i = 0; i < int'(NREG); i++) r.regs[i] = reset_val(addr_t'(i));
        return r;
    endfunction

    rf_t   rf_d, rf_q;
    addr_t w_addr;
    data_t w_data;

    assign w_addr = word[ADDR_W-1:0];
    assign w_data = word[WORD_W-1:ADDR_W];

    always_comb begin
        rf_d     = rf_q;
        rf_d.cal = 1'b0;
        rf_d.stb = 1'b0;
        rf_d.ce  = ce_s;
        if (rf_q.ce && !ce_s) rf_d.relock = 1'b1;
        if (word_vld && is_user(w_addr)) begin
            if (w_addr == addr_t'(PWR_ADDR)) begin
                rf_d.stb   = 1'b1;
                rf_d.waddr = w_addr;
                if (w_data[RST_BIT]) begin
                    for (int i = 0; i < int'(NREG); i++) rf_d.regs[i] = reset_val(addr_t'(i));
                    rf_d.held = 1'b1;
                end else if (rf_q.held) begin
                    rf_d.held = 1'b0;
                end else begin
                    rf_d.regs[PWR_ADDR] = w_data;
                end
            end else if (!rf_q.held) begin
                rf_d.stb          = 1'b1;
                rf_d.waddr        = w_addr;
                rf_d.regs[w_addr] = w_data;
                if (w_addr == addr_t'(CAL_ADDR)) begin
                    rf_d.cal = 1'b1;
                    if (ce_s) rf_d.relock = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= rf_init();
        else        rf_q <= rf_d;
    end

    assign reg_rd     = rf_q.regs;
    assign pwr_en     = rf_q.regs[PWR_ADDR][NPWR-1:0] & {NPWR{ce_s}};
    assign cal_start  = rf_q.cal;
    assign wr_stb     = rf_q.stb;
    assign wr_addr    = rf_q.waddr;
    assign relock_req = rf_q.relock;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_port_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    input  logic              chip_en,
    output logic [NPWR-1:0]   pwr_en,
    output logic              cal_start,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              relock_req,
    output logic [RD_W-1:0]   reg_rd
);
    localparam int unsigned N_IN = 4;

    logic [N_IN-1:0]   pins_s;
    logic [WORD_W-1:0] word;
    logic              word_vld;

    cfg_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({chip_en, ser_le, ser_dat, ser_clk}),
        .sync_o  (pins_s)
    );

    cfg_shifter shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[0]),
        .sdat_s     (pins_s[1]),
        .sle_s      (pins_s[2]),
        .word_o     (word),
        .word_vld_o (word_vld)
    );

    cfg_regfile rf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld   (word_vld),
        .word       (word),
        .ce_s       (pins_s[3]),
        .reg_rd     (reg_rd),
        .pwr_en     (pwr_en),
        .cal_start  (cal_start),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .relock_req (relock_req)
    );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
    import cfg_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic [NPWR-1:0]   pwr_en,
    input logic              cal_start,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              relock_req,
    input logic [RD_W-1:0]   reg_rd
);
    AST_CAL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start); // R7

    AST_CAL_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> (wr_stb && wr_addr == addr_t'(CAL_ADDR))); // R7

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R8

    AST_NO_STB_UNASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr <= addr_t'(9) || wr_addr == addr_t'(12))); // R3

    AST_HIDDEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(reg_rd[10*DATA_W +: DATA_W]) && $stable(reg_rd[13*DATA_W +: DATA_W])); // R3

    AST_CE_LOW_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && !$past(chip_en) && !$past(chip_en, 2) && !$past(chip_en, 3)) |-> pwr_en == '0); // R9

    AST_RELOCK_CLEAR_BY_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(relock_req) |-> cal_start); // R9
endmodule

bind cfg_serial_port cfg_serial_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .pwr_en     (pwr_en),
    .cal_start  (cal_start),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .relock_req (relock_req),
    .reg_rd     (reg_rd)
);

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
    logic [7:0]   pwr_en;
    logic         cal_start, wr_stb, relock_req;
    logic [3:0]   wr_addr;
    logic [319:0] reg_rd;

    int n_chk = 0, n_fail = 0, cal_cnt = 0, stb_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .chip_en(chip_en), .pwr_en(pwr_en),
        .cal_start(cal_start), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .relock_req(relock_req), .reg_rd(reg_rd)
    );

    always @(posedge clk) begin
        if (cal_start) cal_cnt++;
        if (wr_stb)    stb_cnt++;
    end

    function automatic logic [19:0] rd(int a);
        return reg_rd[a*20 +: 20];
    endfunction

    function automatic logic [19:0] hid(int a);
        return {12'hC3A, 4'(a), 4'h0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            ser_dat = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_le();
        wait_clk(4);
        ser_le = 1'b1;
        wait_clk(4);
        ser_le = 1'b0;
        wait_clk(10);
    endtask

    task automatic send(logic [3:0] a, logic [19:0] d);
        shift_bits({d, a});
        pulse_le();
    endtask

    task automatic t_reset();
        chk("R10 pwr_en", 32'(pwr_en), 0);
        chk("R10 relock", 32'(relock_req), 0);
        chk("R10 reg0", 32'(rd(0)), 0);
        chk("R10 reg12", 32'(rd(12)), 0);
        chk("R3 hidden10", 32'(rd(10)), 32'(hid(10)));
        chk("R3 hidden11", 32'(rd(11)), 32'(hid(11)));
        chk("R3 hidden13", 32'(rd(13)), 32'(hid(13)));
    endtask

    task automatic t_basic();
        int s0;
        s0 = stb_cnt;
        send(4'd3, 20'hABCDE);
        chk("R2 reg3", 32'(rd(3)), 32'h000ABCDE);
        send(4'd12, 20'h12345);
        chk("R2 reg12", 32'(rd(12)), 32'h00012345);
        send(4'd9, 20'h80001);
        chk("R1 msb/lsb reg9", 32'(rd(9)), 32'h00080001);
        chk("R1 reg8 untouched", 32'(rd(8)), 0);
        chk("R8 strobes", 32'(stb_cnt - s0), 3);
        chk("R8 last addr", 32'(wr_addr), 9);
    endtask

    task automatic t_ignored();
        int s0;
        s0 = stb_cnt;
        send(4'd10, 20'h11111);
        send(4'd13, 20'h22222);
        send(4'd14, 20'h33333);
        send(4'd15, 20'h44444);
        chk("R3 hidden10 kept", 32'(rd(10)), 32'(hid(10)));
        chk("R3 hidden13 kept", 32'(rd(13)), 32'(hid(13)));
        chk("R3 reg14", 32'(rd(14)), 0);
        chk("R3 reg15", 32'(rd(15)), 0);
        chk("R3 no strobe", 32'(stb_cnt - s0), 0);
    endtask

    task automatic t_cal();
        int c0;
        c0 = cal_cnt;
        send(4'd0, 20'h0F0F0);
        chk("R7 reg0", 32'(rd(0)), 32'h000F0F0);
        send(4'd0, 20'h0F0F0);
        chk("R7 two pulses same value", 32'(cal_cnt - c0), 2);
        send(4'd1, 20'h00005);
        chk("R7 no pulse other addr", 32'(cal_cnt - c0), 2);
    endtask

    task automatic t_power();
        int c0, s0;
        send(4'd5, 20'h000FF);
        chk("R6 enables on", 32'(pwr_en), 32'hFF);
        send(4'd5, 20'h800FF);
        chk("R4 pwr_en off", 32'(pwr_en), 0);
        chk("R4 reg3 cleared", 32'(rd(3)), 0);
        chk("R4 reg0 cleared", 32'(rd(0)), 0);
        chk("R4 reg12 cleared", 32'(rd(12)), 0);
        chk("R4 hidden11", 32'(rd(11)), 32'(hid(11)));
        c0 = cal_cnt;
        s0 = stb_cnt;
        send(4'd3, 20'h55555);
        send(4'd0, 20'h00777);
        chk("R5 reg3 held", 32'(rd(3)), 0);
        chk("R5 reg0 held", 32'(rd(0)), 0);
        chk("R7 no cal held", 32'(cal_cnt - c0), 0);
        chk("R8 no strobe held", 32'(stb_cnt - s0), 0);
        send(4'd5, 20'h000FF);
        chk("R5 release keeps reg5", 32'(rd(5)), 0);
        chk("R5 release no enables", 32'(pwr_en), 0);
        chk("R8 release strobes", 32'(stb_cnt - s0), 1);
        send(4'd5, 20'h000A5);
        chk("R6 third write", 32'(pwr_en), 32'hA5);
        send(4'd3, 20'h00333);
        chk("R5 writes after release", 32'(rd(3)), 32'h333);
    endtask

    task automatic t_chip_en();
        chip_en = 1'b0;
        wait_clk(8);
        chk("R9 gated", 32'(pwr_en), 0);
        chk("R9 reg5 kept", 32'(rd(5)), 32'hA5);
        chk("R9 relock set", 32'(relock_req), 1);
        chip_en = 1'b1;
        wait_clk(8);
        chk("R9 enables back", 32'(pwr_en), 32'hA5);
        chk("R9 relock holds", 32'(relock_req), 1);
        send(4'd2, 20'h00002);
        chk("R9 other write keeps flag", 32'(relock_req), 1);
        send(4'd0, 20'h00010);
        chk("R9 relock cleared", 32'(relock_req), 0);
    endtask

    task automatic t_le_high();
        shift_bits({20'h2468A, 4'd2});
        wait_clk(4);
        ser_le = 1'b1;
        wait_clk(8);
        shift_bits({20'hFEDCB, 4'd4});
        ser_le = 1'b0;
        wait_clk(8);
        ser_le = 1'b1;
        wait_clk(8);
        ser_le = 1'b0;
        wait_clk(10);
        chk("R1 reg2 relatched", 32'(rd(2)), 32'h2468A);
        chk("R1 no shift when le high", 32'(rd(4)), 0);
    endtask

    task automatic t_async_reset();
        chip_en = 1'b0;
        wait_clk(8);
        chip_en = 1'b1;
        wait_clk(2);
        rst_n = 1'b0;
        wait_clk(3);
        chk("R10 relock cleared", 32'(relock_req), 0);
        chk("R10 reg3 default", 32'(rd(3)), 0);
        chk("R10 reg5 default", 32'(rd(5)), 0);
        rst_n = 1'b1;
        wait_clk(4);
        send(4'd7, 20'h00707);
        chk("R10 not held after reset", 32'(rd(7)), 32'h707);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_basic();
        t_ignored();
        t_cal();
        t_power();
        t_chip_en();
        t_le_high();
        t_async_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule